// File: doc/BRIEF.md
# Decimal Edit Pattern Engine

This block formats a string of decimal digits under the control of a small pattern program. After a start pulse it fetches pattern bytes one at a time. Each byte is an operator, and some operators are followed by one operand byte. The engine pulls source digits through an indexed digit port as the operators need them. It writes characters to a destination buffer through a byte write port that carries its own address.

Most operators append at the current destination pointer. Two operators go back and overwrite bytes that were already written, which is why the write port carries an address. The engine holds a fill character, a sign character and three flags: significance, zero and overflow. With these it can substitute leading zeros, float a sign, insert characters that blank out, and blank a field whose value is zero.

When the edit ends, a one-cycle done pulse reports the final destination pointer and the negative, zero and overflow flags. An unknown operator, or an input-length operand that is out of range, ends the edit early with an error.

Top module: `dec_edit_engine`

## Requirements
- R1: After reset and after each start, the fill and sign characters are 0x20, the zero flag is set, and significance and overflow are clear. While idle the block performs no destination write and no digit read.
- R2: An operator with high nibble 0x8 writes the fill character as many times as its low nibble says, at consecutive addresses starting at the pointer. A count of 0 writes nothing.
- R3: An operator with high nibble 0x9 takes one digit per repetition, as many times as its low nibble says. A nonzero digit sets significance and clears zero. The digit is written as 0x30 plus its value when significance is set, and as the fill character otherwise.
- R4: An operator with high nibble 0xA takes digits in the same way. When a nonzero digit arrives while significance is clear, the engine first writes the sign character, sets significance and clears zero, and then writes the digit. Digits that are still insignificant are written as the fill character.
- R5: Operator 0x44 with a character operand writes that character if significance is set, and the fill character otherwise.
- R6: Operand-taking operators 0x40 and 0x41 load the fill and sign characters. Operator 0x42 loads the sign character only for a positive source, and 0x43 only for a negative source.
- R7: Operator 0x02 clears significance and 0x03 sets it. Operator 0x04 writes the sign character. Operator 0x01 writes the sign character and sets significance only while significance is clear. Operator 0x00 ends the edit.
- R8: Operator 0x47 with length L, when more than L source digits remain, reads and discards the excess leading digits. Any nonzero discarded digit sets overflow and significance and clears zero.
- R9: Operator 0x47 with length L, when fewer than L digits remain, arranges for the shortfall to be supplied as leading zero digits before the real ones. A digit requested after the source is used up reads as zero.
- R10: Operator 0x45 with length N, when the zero flag is set, overwrites the N bytes just below the pointer with the fill character and leaves the pointer unchanged.
- R11: Operator 0x46 with length N, when the zero flag is set and N is nonzero, overwrites the byte N places below the pointer with the fill character.
- R12: An opcode not listed in R2 to R11, or an operand of 0x47 outside 1 to 31, ends the edit at once with done and error. No further writes occur.
- R13: Done is a one-cycle pulse. At done, the pointer equals the number of forward writes. The negative flag is the source sign ANDed with NOT zero, and the zero and overflow flags are the edit's final values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an edit (ignored while busy) |
| src_len | input | LENW | Number of source digits |
| src_neg | input | 1 | Source sign, 1 = negative |
| pat_addr | output | PAW | Pattern byte address |
| pat_data | input | 8 | Pattern byte at pat_addr (same cycle) |
| dig_addr | output | LENW | Index of the next source digit |
| dig_rd | output | 1 | A source digit is consumed this cycle |
| dig_data | input | 4 | BCD digit at dig_addr (same cycle) |
| dst_we | output | 1 | Destination write strobe |
| dst_addr | output | DAW | Destination write address |
| dst_data | output | 8 | Destination write character |
| busy | output | 1 | Edit in progress |
| done | output | 1 | One-cycle end-of-edit pulse |
| err | output | 1 | With done: edit stopped on a bad operator or length |
| end_ptr | output | DAW | Destination pointer |
| flag_n | output | 1 | Negative result flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench uses the defaults PAW=8, DAW=8 and LENW=5. A five-bit digit count lets the input-length operator be tried at both its legal ends and at 32, one past the top. An eight-bit destination pointer keeps the backward rewrites in plain subtraction. Short pattern programs walk each operator family: the repeat counts including zero, zero padding, excess digits with and without overflow, a floating sign that never finds a significant digit, and zero-blanking over bytes already written. Bytes past the final pointer are checked as untouched.

// File: rtl/dec_edit_pkg.sv
package dec_edit_pkg;

  localparam int ADJ_MAX = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_OP, S_ARG, S_REP, S_BLANK, S_SKIP
  } state_t;

  typedef enum logic [1:0] {RK_FILL, RK_MOVE, RK_FLOAT} rep_t;

  localparam logic [7:0] OP_END    = 8'h00;
  localparam logic [7:0] OP_ENDFLT = 8'h01;
  localparam logic [7:0] OP_CLRSIG = 8'h02;
  localparam logic [7:0] OP_SETSIG = 8'h03;
  localparam logic [7:0] OP_STSIGN = 8'h04;
  localparam logic [7:0] OP_LDFILL = 8'h40;
  localparam logic [7:0] OP_LDSIGN = 8'h41;
  localparam logic [7:0] OP_LDPLUS = 8'h42;
  localparam logic [7:0] OP_LDMIN  = 8'h43;
  localparam logic [7:0] OP_INSERT = 8'h44;
  localparam logic [7:0] OP_BLANK  = 8'h45;
  localparam logic [7:0] OP_REPL   = 8'h46;
  localparam logic [7:0] OP_ADJ    = 8'h47;

  localparam logic [3:0] GRP_FILL  = 4'h8;
  localparam logic [3:0] GRP_MOVE  = 4'h9;
  localparam logic [3:0] GRP_FLOAT = 4'hA;

  localparam logic [7:0] BLANK_CH = 8'h20;

  // Character for a significant BCD digit
  function automatic logic [7:0] digit_char(input logic [3:0] d);
    return {4'h3, d};
  endfunction

  // Legal operand range of the input-length operator
  function automatic logic adj_len_ok(input logic [7:0] l);
    return (l != 8'd0) && (int'(l) <= ADJ_MAX);
  endfunction

  // Operators that are followed by one operand byte
  function automatic logic has_operand(input logic [7:0] op);
    return op[7:3] == 5'b01000;
  endfunction

endpackage

// File: rtl/dec_edit_digits.sv
module dec_edit_digits #(
  parameter int LENW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LENW-1:0] len_in,
  input  logic            take,
  input  logic            adj,
  input  logic [LENW-1:0] adj_len,
  input  logic [3:0]      mem_data,
  output logic [LENW-1:0] mem_addr,
  output logic            mem_rd,
  output logic [3:0]      cur_digit,
  output logic [LENW-1:0] remaining
);

  logic [LENW-1:0] rem_q, pad_q, idx_q;
  logic            use_pad, have_real;

  assign use_pad   = pad_q != '0;
  assign have_real = !use_pad && (rem_q != '0);
  assign cur_digit = have_real ? mem_data : 4'h0;
  assign mem_rd    = take && have_real;
  assign mem_addr  = idx_q;
  assign remaining = rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      pad_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      rem_q <= len_in;
      pad_q <= '0;
      idx_q <= '0;
    end else if (adj) begin
      pad_q <= (rem_q < adj_len) ? adj_len - rem_q : '0;
    end else if (take) begin
      if (use_pad) begin
        pad_q <= pad_q - 1'b1;
      end else if (rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dec_edit_regs.sv
module dec_edit_regs
  import dec_edit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       ld_fill,
  input  logic       ld_sign,
  input  logic [7:0] ch,
  input  logic       set_sig,
  input  logic       clr_sig,
  input  logic       nz_ev,
  input  logic       ovf_ev,
  output logic [7:0] fill,
  output logic [7:0] sign,
  output logic       sig,
  output logic       zero,
  output logic       ovf
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= BLANK_CH;
      sign <= BLANK_CH;
      sig  <= 1'b0;
      zero <= 1'b1;
      ovf  <= 1'b0;
    end else if (init) begin
      fill <= BLANK_CH;
      sign <= BLANK_CH;
      sig  <= 1'b0;
      zero <= 1'b1;
      ovf  <= 1'b0;
    end else begin
      if (ld_fill) fill <= ch;
      if (ld_sign) sign <= ch;
      if (clr_sig) sig <= 1'b0;
      if (set_sig || nz_ev || ovf_ev) sig <= 1'b1;
      if (nz_ev || ovf_ev) zero <= 1'b0;
      if (ovf_ev) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/dec_edit_engine.sv
module dec_edit_engine
  import dec_edit_pkg::*;
#(
  parameter int PAW  = 8,
  parameter int DAW  = 8,
  parameter int LENW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LENW-1:0] src_len,
  input  logic            src_neg,
  output logic [PAW-1:0]  pat_addr,
  input  logic [7:0]      pat_data,
  output logic [LENW-1:0] dig_addr,
  output logic            dig_rd,
  input  logic [3:0]      dig_data,
  output logic            dst_we,
  output logic [DAW-1:0]  dst_addr,
  output logic [7:0]      dst_data,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [DAW-1:0]  end_ptr,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_v
);

  localparam int CW = 8;

  state_t          st, st_nx;
  rep_t            rk_q, rk_val;
  logic [PAW-1:0]  pc;
  logic [DAW-1:0]  dptr;
  logic [CW-1:0]   cnt, cnt_val;
  logic [7:0]      op_q;
  logic            neg_q, done_q, err_q;

  // Named internal events
  logic            init, pc_inc, cnt_ld, cnt_dec, op_ld, rk_ld;
  logic            fwd_wr, back_wr, take, adj;
  logic            ld_fill, ld_sign, set_sig, clr_sig, nz_ev, ovf_ev;
  logic            fin, fin_err;
  logic [DAW-1:0]  back_addr;
  logic [7:0]      wr_data;

  logic [7:0]      fill, sign;
  logic            sig, zero, ovf;
  logic [3:0]      cur_digit;
  logic [LENW-1:0] remaining;
  logic            nzd;

  dec_edit_digits #(.LENW(LENW)) u_digits (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (init),
    .len_in    (src_len),
    .take      (take),
    .adj       (adj),
    .adj_len   (LENW'(pat_data)),
    .mem_data  (dig_data),
    .mem_addr  (dig_addr),
    .mem_rd    (dig_rd),
    .cur_digit (cur_digit),
    .remaining (remaining)
  );

  dec_edit_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (init),
    .ld_fill (ld_fill),
    .ld_sign (ld_sign),
    .ch      (pat_data),
    .set_sig (set_sig),
    .clr_sig (clr_sig),
    .nz_ev   (nz_ev),
    .ovf_ev  (ovf_ev),
    .fill    (fill),
    .sign    (sign),
    .sig     (sig),
    .zero    (zero),
    .ovf     (ovf)
  );

  assign nzd = cur_digit != 4'h0;

  always_comb begin
    st_nx     = st;
    init      = 1'b0;
    pc_inc    = 1'b0;
    cnt_ld    = 1'b0;
    cnt_val   = '0;
    cnt_dec   = 1'b0;
    op_ld     = 1'b0;
    rk_ld     = 1'b0;
    rk_val    = RK_FILL;
    fwd_wr    = 1'b0;
    back_wr   = 1'b0;
    back_addr = dptr;
    wr_data   = fill;
    take      = 1'b0;
    adj       = 1'b0;
    ld_fill   = 1'b0;
    ld_sign   = 1'b0;
    set_sig   = 1'b0;
    clr_sig   = 1'b0;
    nz_ev     = 1'b0;
    ovf_ev    = 1'b0;
    fin       = 1'b0;
    fin_err   = 1'b0;
    case (st)
      S_IDLE: begin
        if (start) begin
          init  = 1'b1;
          st_nx = S_OP;
        end
      end
      S_OP: begin
        if (pat_data[7:4] == GRP_FILL || pat_data[7:4] == GRP_MOVE ||
            pat_data[7:4] == GRP_FLOAT) begin
          pc_inc = 1'b1;
          rk_ld  = 1'b1;
          rk_val = (pat_data[7:4] == GRP_FILL) ? RK_FILL :
                   (pat_data[7:4] == GRP_MOVE) ? RK_MOVE : RK_FLOAT;
          if (pat_data[3:0] != 4'h0) begin
            cnt_ld  = 1'b1;
            cnt_val = CW'(pat_data[3:0]);
            st_nx   = S_REP;
          end
        end else if (has_operand(pat_data)) begin
          pc_inc = 1'b1;
          op_ld  = 1'b1;
          st_nx  = S_ARG;
        end else begin
          case (pat_data)
            OP_END: fin = 1'b1;
            OP_ENDFLT: begin
              pc_inc = 1'b1;
              if (!sig) begin
                fwd_wr  = 1'b1;
                wr_data = sign;
                set_sig = 1'b1;
              end
            end
            OP_CLRSIG: begin
              pc_inc  = 1'b1;
              clr_sig = 1'b1;
            end
            OP_SETSIG: begin
              pc_inc  = 1'b1;
              set_sig = 1'b1;
            end
            OP_STSIGN: begin
              pc_inc  = 1'b1;
              fwd_wr  = 1'b1;
              wr_data = sign;
            end
            default: fin_err = 1'b1;
          endcase
        end
      end
      S_ARG: begin
        pc_inc = 1'b1;
        st_nx  = S_OP;
        case (op_q)
          OP_LDFILL: ld_fill = 1'b1;
          OP_LDSIGN: ld_sign = 1'b1;
          OP_LDPLUS: ld_sign = !neg_q;
          OP_LDMIN:  ld_sign = neg_q;
          OP_INSERT: begin
            fwd_wr  = 1'b1;
            wr_data = sig ? pat_data : fill;
          end
          OP_BLANK: begin
            if (zero && pat_data != 8'd0) begin
              cnt_ld  = 1'b1;
              cnt_val = pat_data;
              st_nx   = S_BLANK;
            end
          end
          OP_REPL: begin
            if (zero && pat_data != 8'd0) begin
              back_wr   = 1'b1;
              back_addr = dptr - DAW'(pat_data);
            end
          end
          OP_ADJ: begin
            if (!adj_len_ok(pat_data)) begin
              pc_inc  = 1'b0;
              fin_err = 1'b1;
            end else begin
              adj = 1'b1;
              if (CW'(remaining) > pat_data) begin
                cnt_ld  = 1'b1;
                cnt_val = CW'(remaining) - pat_data;
                st_nx   = S_SKIP;
              end
            end
          end
          default: fin_err = 1'b1;
        endcase
      end
      S_REP: begin
        fwd_wr = 1'b1;
        case (rk_q)
          RK_FILL: cnt_dec = 1'b1;
          RK_MOVE: begin
            take    = 1'b1;
            cnt_dec = 1'b1;
            nz_ev   = nzd;
            wr_data = (sig || nzd) ? digit_char(cur_digit) : fill;
          end
          default: begin
            nz_ev = nzd;
            if (nzd && !sig) begin
              wr_data = sign;
            end else begin
              take    = 1'b1;
              cnt_dec = 1'b1;
              wr_data = sig ? digit_char(cur_digit) : fill;
            end
          end
        endcase
        if (cnt_dec && cnt == CW'(1)) st_nx = S_OP;
      end
      S_BLANK: begin
        back_wr   = 1'b1;
        back_addr = dptr - DAW'(cnt);
        cnt_dec   = 1'b1;
        if (cnt == CW'(1)) st_nx = S_OP;
      end
      S_SKIP: begin
        take    = 1'b1;
        ovf_ev  = nzd;
        cnt_dec = 1'b1;
        if (cnt == CW'(1)) st_nx = S_OP;
      end
      default: st_nx = S_IDLE;
    endcase
    if (fin || fin_err) st_nx = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pc     <= '0;
      dptr   <= '0;
      cnt    <= '0;
      op_q   <= '0;
      rk_q   <= RK_FILL;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= fin || fin_err;
      err_q  <= fin_err;
      if (init) begin
        pc    <= '0;
        dptr  <= '0;
        neg_q <= src_neg;
      end else begin
        if (pc_inc) pc <= pc + 1'b1;
        if (fwd_wr) dptr <= dptr + 1'b1;
      end
      if (cnt_ld) cnt <= cnt_val;
      else if (cnt_dec) cnt <= cnt - 1'b1;
      if (op_ld) op_q <= pat_data;
      if (rk_ld) rk_q <= rk_val;
    end
  end

  assign pat_addr = pc;
  assign dst_we   = fwd_wr || back_wr;
  assign dst_addr = back_wr ? back_addr : dptr;
  assign dst_data = wr_data;
  assign busy     = st != S_IDLE;
  assign done     = done_q;
  assign err      = err_q;
  assign end_ptr  = dptr;
  assign flag_n   = neg_q && !zero;
  assign flag_z   = zero;
  assign flag_v   = ovf;

endmodule

// File: rtl/dec_edit_chk.sv
module dec_edit_chk #(
  parameter int DAW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic           dst_we,
  input logic           dig_rd,
  input logic           fwd_wr,
  input logic           back_wr,
  input logic [DAW-1:0] dst_addr,
  input logic [DAW-1:0] end_ptr,
  input logic           flag_v
);

  // R1: no write or digit read while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dst_we && !dig_rd));

  // R2: every forward write moves the pointer by one
  a_r2_fwd_advance: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_wr |=> end_ptr == $past(end_ptr) + DAW'(1));

  // R11: a backward rewrite never lands on the current pointer
  a_r11_back_behind: assert property (@(posedge clk) disable iff (!rst_n)
    back_wr |-> (dst_addr != end_ptr));

  // R10: a backward rewrite leaves the pointer where it was
  a_r10_back_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (back_wr && !fwd_wr) |=> $stable(end_ptr));

  // R8: overflow cannot clear during an edit
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && flag_v) |=> flag_v);

  // R12: error only comes together with done
  a_r12_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R13: done lasts one cycle
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind dec_edit_engine dec_edit_chk #(.DAW(DAW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .dst_we   (dst_we),
  .dig_rd   (dig_rd),
  .fwd_wr   (fwd_wr),
  .back_wr  (back_wr),
  .dst_addr (dst_addr),
  .end_ptr  (end_ptr),
  .flag_v   (flag_v)
);

// File: tb/test_dec_edit_engine.sv
`timescale 1ns/1ps
module test_dec_edit_engine;

  localparam int PAW  = 8;
  localparam int DAW  = 8;
  localparam int LENW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [LENW-1:0] src_len = '0;
  logic            src_neg = 1'b0;
  logic [PAW-1:0]  pat_addr;
  logic [7:0]      pat_data;
  logic [LENW-1:0] dig_addr;
  logic            dig_rd;
  logic [3:0]      dig_data;
  logic            dst_we;
  logic [DAW-1:0]  dst_addr;
  logic [7:0]      dst_data;
  logic            busy, done, err;
  logic [DAW-1:0]  end_ptr;
  logic            flag_n, flag_z, flag_v;

  always #2.5 clk = ~clk;

  logic [7:0] pmem [256];
  logic [3:0] dmem [32];
  logic [7:0] omem [256];
  logic       clr_out = 1'b0;

  assign pat_data = pmem[pat_addr];
  assign dig_data = dmem[dig_addr];

  always @(posedge clk) begin
    if (clr_out) begin
      for (int k = 0; k < 256; k++) omem[k] <= 8'hEE;
    end else if (dst_we) begin
      omem[dst_addr] <= dst_data;
    end
  end

  dec_edit_engine #(.PAW(PAW), .DAW(DAW), .LENW(LENW)) i_dec_edit_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .src_len(src_len), .src_neg(src_neg),
    .pat_addr(pat_addr), .pat_data(pat_data),
    .dig_addr(dig_addr), .dig_rd(dig_rd), .dig_data(dig_data),
    .dst_we(dst_we), .dst_addr(dst_addr), .dst_data(dst_data),
    .busy(busy), .done(done), .err(err), .end_ptr(end_ptr),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // pattern bytes, digits and expected characters: first item in the top bits
  typedef struct packed {
    logic [63:0] pat;
    logic [31:0] dig;
    logic [4:0]  slen;
    logic        neg;
    logic [63:0] exp;
    logic [3:0]  elen;
    logic [2:0]  nzv;
    logic        err;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{64'h9400000000000000, 32'h01200000, 5'd4, 1'b0, 64'h2031323000000000, 4'd4, 3'b000, 1'b0},
    '{64'h432DA40100000000, 32'h00570000, 5'd4, 1'b1, 64'h20202D3537000000, 4'd5, 3'b100, 1'b0},
    '{64'h412BA30100000000, 32'h00000000, 5'd3, 1'b0, 64'h2020202B00000000, 4'd4, 3'b010, 1'b0},
    '{64'h402A442C03442F81, 32'h00000000, 5'd0, 1'b0, 64'h2A2F2A0000000000, 4'd3, 3'b010, 1'b0},
    '{64'h4702920000000000, 32'h30450000, 5'd4, 1'b0, 64'h3435000000000000, 4'd2, 3'b001, 1'b0},
    '{64'h4705950000000000, 32'h12000000, 5'd2, 1'b0, 64'h2020203132000000, 4'd5, 3'b000, 1'b0},
    '{64'h93402A4502000000, 32'h00000000, 5'd3, 1'b1, 64'h202A2A0000000000, 4'd3, 3'b010, 1'b0},
    '{64'h412D030492460300, 32'h00000000, 5'd2, 1'b1, 64'h2030300000000000, 4'd3, 3'b010, 1'b0},
    '{64'h422B432D04910000, 32'h90000000, 5'd1, 1'b0, 64'h2B39000000000000, 4'd2, 3'b000, 1'b0},
    '{64'h0393000000000000, 32'h70000000, 5'd1, 1'b0, 64'h3730300000000000, 4'd3, 3'b000, 1'b0},
    '{64'h9105910000000000, 32'h12000000, 5'd2, 1'b0, 64'h3100000000000000, 4'd1, 3'b000, 1'b1},
    '{64'h4700000000000000, 32'h00000000, 5'd0, 1'b0, 64'h0000000000000000, 4'd0, 3'b010, 1'b1},
    '{64'h4720000000000000, 32'h00000000, 5'd0, 1'b0, 64'h0000000000000000, 4'd0, 3'b010, 1'b1},
    '{64'h8081000000000000, 32'h00000000, 5'd0, 1'b0, 64'h2000000000000000, 4'd1, 3'b010, 1'b0},
    '{64'h0302910000000000, 32'h00000000, 5'd1, 1'b0, 64'h2000000000000000, 4'd1, 3'b010, 1'b0},
    '{64'h422B432D04000000, 32'h00000000, 5'd0, 1'b1, 64'h2D00000000000000, 4'd1, 3'b010, 1'b0},
    '{64'h4701910000000000, 32'h00700000, 5'd3, 1'b0, 64'h3700000000000000, 4'd1, 3'b000, 1'b0}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0:  return "R3";
      1:  return "R4";
      2:  return "R7";
      3:  return "R5";
      4:  return "R8";
      5:  return "R9";
      6:  return "R10";
      7:  return "R11";
      8:  return "R6";
      9:  return "R9";
      10: return "R12";
      11: return "R12";
      12: return "R12";
      13: return "R2";
      14: return "R7";
      15: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic run_vec(input int i);
    vec_t  v;
    string t;
    int    w;
    logic  seen;
    v = VECS[i];
    t = vec_tag(i);
    for (int k = 0; k < 256; k++) pmem[k] = 8'h00;
    for (int k = 0; k < 8; k++) pmem[k] = v.pat[63-8*k -: 8];
    for (int k = 0; k < 32; k++) dmem[k] = 4'hF;
    for (int k = 0; k < 8; k++) dmem[k] = v.dig[31-4*k -: 4];
    @(negedge clk);
    clr_out = 1'b1;
    @(negedge clk);
    clr_out = 1'b0;
    src_len = v.slen;
    src_neg = v.neg;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    w = 0;
    while (!seen && w < 500) begin
      if (done) seen = 1'b1;
      else begin
        @(negedge clk);
        w++;
      end
    end
    check(t, "done seen", 64'(seen), 64'd1);
    check(t, "error", 64'(err), 64'(v.err));
    check(t, "end pointer", 64'(end_ptr), 64'(v.elen));
    check("R13", "nzv", {61'd0, flag_n, flag_z, flag_v}, 64'(v.nzv));
    for (int k = 0; k < 8; k++) begin
      if (k < int'(v.elen))
        check(t, $sformatf("char %0d", k), 64'(omem[k]), 64'(v.exp[63-8*k -: 8]));
      else
        check(t, $sformatf("untouched %0d", k), 64'(omem[k]), 64'hEE);
    end
    @(negedge clk);
    check("R13", "done single cycle", 64'(done), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) pmem[k] = 8'h00;
    for (int k = 0; k < 32; k++) dmem[k] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state after reset
    check("R1", "busy", 64'(busy), 64'd0);
    check("R1", "done", 64'(done), 64'd0);
    check("R1", "write strobe", 64'(dst_we), 64'd0);
    check("R1", "digit read", 64'(dig_rd), 64'd0);
    check("R1", "pointer", 64'(end_ptr), 64'd0);
    check("R1", "flags", {61'd0, flag_n, flag_z, flag_v}, 64'b010);
    for (int i = 0; i < NV; i++) run_vec(i);
    // R1: flags return to start values on a new edit after overflow
    run_vec(4);
    run_vec(14);
    check("R1", "idle quiet after edits", {62'd0, dst_we, busy}, 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule